// File: doc/BRIEF.md
# Comma and run-length monitor for 8b/10b serial streams

This block sits on the receive side of a serial link that carries 8b/10b code-groups. It takes one line bit per clock, qualified by `bit_vld`, and never alters the stream. From the accepted bits it does three things at once. It polices the run-length rule: a line may carry at most five identical bits in a row. It hunts for the K28.5 comma in both of its disparity forms and aligns a 10-bit symbol framer to the last comma found. It also checks that commas sent back to back swap polarity, as a repeating comma stream must.

The framer is a three-state machine. `ST_HUNT` is the state after reset, and no symbols are framed there. The transition *comma_found* moves any state to `ST_AFTER_COMMA`, and the phase counter restarts at that point. From `ST_AFTER_COMMA`, the transition *data_symbol* moves to `ST_AFTER_DATA` when ten further accepted bits complete a symbol that is not a comma. From `ST_AFTER_DATA`, only *comma_found* leaves the state. Reset returns the machine to `ST_HUNT` from any state. The alternation check is made only on the *comma_found* transition out of `ST_AFTER_COMMA` that lands exactly on a symbol boundary.

Top module: `comma_run_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears every counter, returns the framer to `ST_HUNT`, and drives all outputs to 0 on the following cycle, `sym_data` and `comma_pos` included.
- R2: `run_err` pulses for one cycle after each accepted bit that is the sixth or a later bit in a row equal to the previous accepted bit. Bits with `bit_vld` low do not break the run and do not extend it.
- R3: Take the last ten accepted bits, with the earliest-sent bit as the most significant. When they equal 10'b0011111010 (the negative form), `comma_pulse` is 1 for one cycle with `comma_pos`=0. When they equal 10'b1100000101 (the positive form), `comma_pulse` is 1 for one cycle with `comma_pos`=1. Both take effect the cycle after the completing bit, and no match is possible before ten bits have been accepted since reset.
- R4: In `ST_HUNT` `sym_stb` stays 0. A framed symbol appears on `sym_data`, with the first-sent bit at bit 9 and the last-sent bit at bit 0. `sym_data` holds its value between strobes.
- R5: Once aligned, `sym_stb` is 1 for one cycle after every tenth accepted bit counted from the last comma. A comma that ends exactly on such a boundary is also strobed as a symbol.
- R6: A comma found at any other phase realigns the framer, so that the next strobe comes ten accepted bits after that comma.
- R7: `alt_err` is 1, together with `comma_pulse` and `sym_stb`, when a comma ends on the boundary that directly follows a previous comma and has the same polarity as that comma. A polarity swap, or a data symbol between the two commas, gives no error.
- R8: While `bit_vld` is low nothing advances, and on the next cycle `comma_pulse`, `sym_stb`, `run_err` and `alt_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Line bit, earliest code-group bit first |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| comma_pulse | output | 1 | One-cycle pulse when a K28.5 comma has been seen |
| comma_pos | output | 1 | Polarity of the last comma (1 = positive form) |
| run_err | output | 1 | Run of more than five identical bits |
| alt_err | output | 1 | Back-to-back commas with the same polarity |
| sym_data | output | 10 | Last framed symbol, first bit at the MSB |
| sym_stb | output | 1 | One-cycle strobe for a new `sym_data` |

## Verification
The assertions assume that `bit_vld` and `bit_in` are driven to known values on every cycle once reset is released. They also assume that a comma can complete on the cycle right after a symbol strobe only when it is misaligned, so a strobe is never followed directly by another strobe. The bench keeps to this by driving every input from one task at the falling edge, including random `bit_in` values during idle cycles. It applies long random streams with random idle gaps, aligned and misaligned commas in both polarities, repeated same-polarity commas, over-long runs, and a reset in mid-stream. Each result is compared with a behavioural model that keeps the accepted bits in a queue.

// File: rtl/crm_pkg.sv
package crm_pkg;

    // Width of one code-group on the line.
    localparam int SYM_W = 10;

    // K28.5, earliest-sent bit in the MSB.
    localparam logic [SYM_W-1:0] K_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] K_POS = 10'b1100000101;

    // Number of comma forms searched for.
    localparam int N_FORMS = 2;

    typedef enum logic [1:0] {
        ST_HUNT        = 2'd0,
        ST_AFTER_COMMA = 2'd1,
        ST_AFTER_DATA  = 2'd2
    } align_state_t;

    function automatic logic [SYM_W-1:0] comma_form(input int idx);
        return (idx == 0) ? K_NEG : K_POS;
    endfunction

endpackage

// File: rtl/crm_window.sv
// Sliding window of the most recent accepted bits plus a fill indicator.
module crm_window
    import crm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_vld,
    output logic [SYM_W-1:0] win_next,
    output logic             full_next
);

    localparam int FILL_W   = $clog2(SYM_W);
    localparam int FILL_MAX = SYM_W - 1;

    logic [SYM_W-1:0]  win_q;
    logic [FILL_W-1:0] fill_q;

    // Window as it stands once the current bit is included.
    assign win_next  = {win_q[SYM_W-2:0], bit_in};
    // True when the current bit completes at least SYM_W accepted bits.
    assign full_next = (fill_q == FILL_W'(FILL_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_next;
            if (fill_q != FILL_W'(FILL_MAX)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/crm_comma_detect.sv
// Compares the window with each comma form.
module crm_comma_detect
    import crm_pkg::*;
(
    input  logic [SYM_W-1:0] win,
    input  logic             full,
    output logic             hit_neg,
    output logic             hit_pos
);

    logic [N_FORMS-1:0] hit;

    for (genvar f = 0; f < N_FORMS; f++) begin : g_form
        localparam logic [SYM_W-1:0] FORM = comma_form(f);
        assign hit[f] = full && (win == FORM);
    end

    assign hit_neg = hit[0];
    assign hit_pos = hit[1];

endmodule

// File: rtl/crm_run_check.sv
// Counts identical accepted bits and flags runs beyond MAX_RUN.
module crm_run_check #(
    parameter int MAX_RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic run_err
);

    localparam int               CNT_W = $clog2(MAX_RUN + 2);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(MAX_RUN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RUN);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic             prev_q;
    logic             seen_q;

    always_comb begin
        if (seen_q && (bit_in == prev_q)) begin
            run_d = (run_q == SAT) ? run_q : run_q + 1'b1;
        end else begin
            run_d = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
            run_err <= 1'b0;
        end else if (bit_vld) begin
            run_q   <= run_d;
            prev_q  <= bit_in;
            seen_q  <= 1'b1;
            run_err <= (run_d > LIMIT);
        end else begin
            run_err <= 1'b0;
        end
    end

endmodule

// File: rtl/crm_align_fsm.sv
// Symbol framer: alignment state machine, phase counter and output registers.
module crm_align_fsm
    import crm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_vld,
    input  logic [SYM_W-1:0] win_next,
    input  logic             hit_neg,
    input  logic             hit_pos,
    output logic             comma_pulse,
    output logic             comma_pos,
    output logic             alt_err,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_stb
);

    localparam int               PH_W   = $clog2(SYM_W);
    localparam logic [PH_W-1:0]  PH_END = PH_W'(SYM_W - 1);

    align_state_t    state_q;
    align_state_t    state_d;
    logic [PH_W-1:0] phase_q;

    logic comma_hit;
    logic at_edge;
    logic alt_hit;

    assign comma_hit = bit_vld && (hit_neg || hit_pos);
    assign at_edge   = bit_vld && (state_q != ST_HUNT) && (phase_q == PH_END);
    assign alt_hit   = comma_hit && at_edge && (state_q == ST_AFTER_COMMA)
                       && (hit_pos == comma_pos);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (comma_hit) state_d = ST_AFTER_COMMA;
            end
            ST_AFTER_COMMA: begin
                if (comma_hit)    state_d = ST_AFTER_COMMA;
                else if (at_edge) state_d = ST_AFTER_DATA;
            end
            ST_AFTER_DATA: begin
                if (comma_hit) state_d = ST_AFTER_COMMA;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    // Phase within the current symbol.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (comma_hit) begin
            phase_q <= '0;
        end else if (bit_vld && (state_q != ST_HUNT)) begin
            phase_q <= at_edge ? '0 : phase_q + 1'b1;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            comma_pulse <= 1'b0;
            comma_pos   <= 1'b0;
            alt_err     <= 1'b0;
            sym_stb     <= 1'b0;
            sym_data    <= '0;
        end else begin
            comma_pulse <= comma_hit;
            sym_stb     <= at_edge;
            alt_err     <= alt_hit;
            if (comma_hit) comma_pos <= hit_pos;
            if (at_edge)   sym_data  <= win_next;
        end
    end

endmodule

// File: rtl/comma_run_monitor.sv
// 8b/10b comma alignment and run-length monitor.
module comma_run_monitor
    import crm_pkg::*;
#(
    parameter int MAX_RUN = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             bit_vld,
    output logic             comma_pulse,
    output logic             comma_pos,
    output logic             run_err,
    output logic             alt_err,
    output logic [SYM_W-1:0] sym_data,
    output logic             sym_stb
);

    logic [SYM_W-1:0] win_next;
    logic             full_next;
    logic             hit_neg;
    logic             hit_pos;

    crm_window u_window (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .win_next  (win_next),
        .full_next (full_next)
    );

    crm_comma_detect u_detect (
        .win     (win_next),
        .full    (full_next),
        .hit_neg (hit_neg),
        .hit_pos (hit_pos)
    );

    crm_run_check #(.MAX_RUN(MAX_RUN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .run_err (run_err)
    );

    crm_align_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .bit_vld     (bit_vld),
        .win_next    (win_next),
        .hit_neg     (hit_neg),
        .hit_pos     (hit_pos),
        .comma_pulse (comma_pulse),
        .comma_pos   (comma_pos),
        .alt_err     (alt_err),
        .sym_data    (sym_data),
        .sym_stb     (sym_stb)
    );

endmodule

// File: rtl/crm_checker.sv
// Port-level properties of comma_run_monitor.
module crm_checker
    import crm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_vld,
    input logic             comma_pulse,
    input logic             comma_pos,
    input logic             run_err,
    input logic             alt_err,
    input logic [SYM_W-1:0] sym_data,
    input logic             sym_stb
);

    // R1: the cycle after reset is quiet.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!comma_pulse && !sym_stb && !run_err && !alt_err
                        && (sym_data == '0) && !comma_pos));

    // R2: a run error needs an accepted bit.
    p_run_needs_bit_r2: assert property (@(posedge clk) disable iff (rst)
        run_err |-> $past(bit_vld));

    // R3: a comma on a boundary is framed with the matching form.
    p_comma_framed_r3: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && comma_pulse) |-> (sym_data == (comma_pos ? K_POS : K_NEG)));

    // R5: strobes are single-cycle.
    p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> !sym_stb);

    // R7: alternation error only with a comma on a boundary.
    p_alt_on_comma_r7: assert property (@(posedge clk) disable iff (rst)
        alt_err |-> (comma_pulse && sym_stb));

    // R8: idle cycles produce no pulses.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_vld) |-> (!comma_pulse && !sym_stb && !run_err && !alt_err));

endmodule

bind comma_run_monitor crm_checker u_crm_checker (
    .clk         (clk),
    .rst         (rst),
    .bit_vld     (bit_vld),
    .comma_pulse (comma_pulse),
    .comma_pos   (comma_pos),
    .run_err     (run_err),
    .alt_err     (alt_err),
    .sym_data    (sym_data),
    .sym_stb     (sym_stb)
);

// File: tb/test_comma_run_monitor.sv
`timescale 1ns/1ps
module test_comma_run_monitor;

    localparam logic [9:0] KN = 10'b0011111010;
    localparam logic [9:0] KP = 10'b1100000101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       comma_pulse, comma_pos, run_err, alt_err, sym_stb;
    logic [9:0] sym_data;

    always #2 clk = ~clk;

    comma_run_monitor i_comma_run_monitor (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .comma_pulse(comma_pulse), .comma_pos(comma_pos), .run_err(run_err),
        .alt_err(alt_err), .sym_data(sym_data), .sym_stb(sym_stb)
    );

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    bit    gaps = 1'b0;
    string phase_tag = "R1 reset";

    // Reference model state.
    bit         hist[$];
    int         run_len;
    bit         prev_bit;
    bit         have_prev;
    int         st;        // 0 hunt, 1 after comma, 2 after data
    int         phase;
    logic       e_pulse, e_pos, e_run, e_alt, e_stb;
    logic [9:0] e_data;

    task automatic model_reset();
        hist.delete();
        run_len = 0; prev_bit = 0; have_prev = 0;
        st = 0; phase = 0;
        e_pulse = 0; e_pos = 0; e_run = 0; e_alt = 0; e_stb = 0; e_data = '0;
    endtask

    task automatic model_step(input logic r, input logic v, input logic b);
        logic [9:0] w;
        bit is_neg, is_pos, is_comma, edge_hit;
        if (r) begin
            model_reset();
            return;
        end
        e_pulse = 0; e_run = 0; e_alt = 0; e_stb = 0;
        if (!v) return;
        hist.push_back(b);
        if (hist.size() > 10) void'(hist.pop_front());
        w = '0;
        for (int i = 0; i < hist.size(); i++) w = {w[8:0], hist[i]};
        is_neg   = (hist.size() == 10) && (w == KN);
        is_pos   = (hist.size() == 10) && (w == KP);
        is_comma = is_neg || is_pos;
        if (have_prev && b == prev_bit) run_len++;
        else run_len = 1;
        have_prev = 1; prev_bit = b;
        e_run = (run_len > 5);
        edge_hit = (st != 0) && (phase == 9);
        e_stb = edge_hit;
        if (edge_hit) e_data = w;
        e_alt = is_comma && edge_hit && (st == 1) && (is_pos == e_pos);
        e_pulse = is_comma;
        if (is_comma) begin
            st = 1; phase = 0; e_pos = is_pos;
        end else if (st != 0) begin
            if (edge_hit) begin phase = 0; st = 2; end
            else phase++;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s during '%s' at %0t: actual %b expected %b",
                     req, what, phase_tag, $time, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic b);
        @(negedge clk);
        rst = r; bit_vld = v; bit_in = b;
        @(posedge clk);
        #1;
        model_step(r, v, b);
        vectors++;
        chk("R3", "comma_pulse", {9'b0, comma_pulse}, {9'b0, e_pulse});
        chk("R3", "comma_pos",   {9'b0, comma_pos},   {9'b0, e_pos});
        chk("R2", "run_err",     {9'b0, run_err},     {9'b0, e_run});
        chk("R7", "alt_err",     {9'b0, alt_err},     {9'b0, e_alt});
        chk("R5", "sym_stb",     {9'b0, sym_stb},     {9'b0, e_stb});
        chk("R4", "sym_data",    sym_data,            e_data);
    endtask

    task automatic send_bit(input logic b);
        if (gaps && ($urandom_range(0, 3) == 0)) step(1'b0, 1'b0, 1'($urandom));
        step(1'b0, 1'b1, b);
    endtask

    task automatic send_sym(input logic [9:0] s);
        for (int i = 9; i >= 0; i--) send_bit(s[i]);
    endtask

    task automatic send_random(input int n);
        for (int i = 0; i < n; i++) send_bit(1'($urandom));
    endtask

    initial begin
        model_reset();
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);

        // R4: no framing while hunting
        phase_tag = "R4 hunt";
        send_sym(10'b1000110001);
        send_sym(10'b1010101010);

        // R3 R5: alternating commas with data between
        phase_tag = "R3 R5 alternating commas";
        send_sym(KN); send_sym(10'b1000110001);
        send_sym(KP); send_sym(10'b0111100100);
        send_sym(KN); send_sym(KP); send_sym(KN); send_sym(KP);
        send_sym(10'b1001110100);

        // R7: same polarity back to back
        phase_tag = "R7 repeated polarity";
        send_sym(KN); send_sym(KN); send_sym(KN);
        send_sym(10'b1010101010);
        send_sym(KP); send_sym(KP);
        send_sym(KN); send_sym(10'b0111100100); send_sym(KN);

        // R6: misaligned comma realigns
        phase_tag = "R6 realign";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_sym(KP); send_sym(10'b1000110001); send_sym(KN);
        send_bit(1'b0); send_bit(1'b1);
        send_sym(KP); send_sym(10'b1010101010);

        // R2: over-long runs
        phase_tag = "R2 run length";
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_bit(1'b0);

        // R8: idle gaps between accepted bits
        phase_tag = "R8 gaps";
        gaps = 1'b1;
        send_sym(KN); send_sym(10'b1001110100); send_sym(KP); send_sym(KP);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, 1'b1);
        end
        for (int i = 0; i < 6; i++) send_bit(1'b0);

        // Mixed random traffic with commas
        phase_tag = "R2 R3 R5 R6 R7 R8 random";
        for (int k = 0; k < 120; k++) begin
            send_random($urandom_range(0, 25));
            send_sym($urandom_range(0, 1) ? KP : KN);
            if ($urandom_range(0, 1) == 1) send_sym($urandom_range(0, 1) ? KP : KN);
        end

        // R1: reset in mid-stream
        phase_tag = "R1 mid reset";
        gaps = 1'b0;
        send_sym(KN);
        send_bit(1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        send_sym(10'b1000110001);
        send_sym(KP); send_sym(10'b1010101010);
        send_random(300);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired during '%s'", phase_tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule